// File: doc/BRIEF.md
# Data-to-Reference Frequency Ratio Meter

This block measures how fast a recovered data clock runs compared with a reference clock. The reference first passes through a power-of-two prescaler, selected by a two-bit range field, which brings any reference from 12.3 MHz to 200 MHz down into a 12.3 MHz to 25 MHz base band. The prescaled reference then opens a measurement window that lasts a fixed number of base-band periods. During that window the block counts recovered-clock edges. The final count is the frequency ratio scaled by the window length. With the default window of 10000 base-band periods, and a data clock at least as fast as the base band, one count is worth no more than 100 ppm of the result.

The window is generated in the reference domain and the counting is done in the recovered-clock domain. The count is captured there and handed to the system clock domain through a toggle handshake. In the system domain it is offered on a valid/ready output. The back-pressure rule is as follows:
- A result stays offered until it is accepted.
- The counter never stalls.
- A newer result overwrites one that has not yet been accepted, so the consumer always sees the latest measurement.

Measurements only run while the measure enable is set and the lock-to-reference enable is clear. Measuring has no effect on the data path. The reference is used only to time the window.

Top module: `freq_ratio_meter`

## Requirements
- R1: The range field `ref_range` divides the reference by 1, 2, 4 or 8 for codes 0, 1, 2 and 3 before the window is timed.
- R2: `ratio_count` equals the number of `rec_clk` periods within `GATE_TICKS` prescaled reference periods, within plus or minus one count.
- R3: When the recovered clock equals the prescaled reference, the count equals `GATE_TICKS` within one count. With the default of 10000, one count is therefore at most 100 ppm of the result.
- R4: `ratio_valid` rises after a measurement completes and stays high while `ratio_ready` is low. `ratio_count` holds steady unless a newer result replaces it.
- R5: A handshake, meaning `ratio_valid` and `ratio_ready` both high at a `sys_clk` edge, clears `ratio_valid` on that edge unless a new result arrives in the same cycle.
- R6: While `meas_en` is low, no result is delivered, and `ratio_valid` is low from the next `sys_clk` edge onward. Clearing `meas_en` aborts a window in progress.
- R7: While `lock_ref_en` is high, no measurement starts, and `ratio_valid` is low from the next `sys_clk` edge onward, even with `meas_en` high.
- R8: After reset, `ratio_valid` is low and `ratio_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; the output side runs on it |
| ref_clk | input | 1 | Reference clock |
| rec_clk | input | 1 | Recovered data clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| meas_en | input | 1 | Measure enable (system domain) |
| lock_ref_en | input | 1 | Lock-to-reference mode flag; blocks measuring |
| ref_range | input | 2 | Prescale code: divide by 2^code |
| ratio_count | output | CNT_W | Latest ratio count |
| ratio_valid | output | 1 | A result is offered |
| ratio_ready | input | 1 | Consumer accepts the offered result |

## Verification
The assertions take three things for granted. First, `meas_en` and `lock_ref_en` are system-domain levels. Second, `ratio_ready` changes only between `sys_clk` edges. Third, at least one full measurement window passes between a change of enable and any result check, so a toggle launched before an abort is no longer in flight. The stimulus respects these assumptions in several ways:
- It drives every control at the falling edge of `sys_clk`.
- It starts each configuration from a disabled state.
- It waits for a fresh result before comparing.

It also keeps the three clock frequencies in fixed, known ratios, so each expected count is a closed-form number.

// File: rtl/freq_ratio_meter_pkg.sv
package freq_ratio_meter_pkg;

  typedef logic [1:0] range_t;

  // Base-band periods the gate stays closed between two windows
  localparam int unsigned GAP_TICKS = 4;

  // Last value of the prescale counter for a given range code (2^code - 1)
  function automatic logic [2:0] pre_last(input range_t code);
    case (code)
      2'd0:    pre_last = 3'd0;
      2'd1:    pre_last = 3'd1;
      2'd2:    pre_last = 3'd3;
      default: pre_last = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/frm_gate_gen.sv
module frm_gate_gen
  import freq_ratio_meter_pkg::*;
#(
  parameter int GATE_TICKS = 10000
) (
  input  logic   ref_clk,
  input  logic   rst_n,
  input  logic   run,
  input  range_t range_in,
  output logic   gate
);
  localparam int MAX_T = (GATE_TICKS > int'(GAP_TICKS)) ? GATE_TICKS : int'(GAP_TICKS);
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] GATE_LAST = CW'(GATE_TICKS - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_TICKS - 1);

  logic [2:0]    pre_cnt;
  range_t        rng_q;
  logic [CW-1:0] ph_cnt;
  logic          tick;

  assign tick = (pre_cnt == pre_last(rng_q));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      rng_q   <= '0;
      ph_cnt  <= '0;
      gate    <= 1'b0;
    end else if (!run) begin
      pre_cnt <= '0;
      rng_q   <= range_in;
      ph_cnt  <= '0;
      gate    <= 1'b0;
    end else begin
      pre_cnt <= tick ? 3'd0 : pre_cnt + 3'd1;
      if (tick) begin
        if (gate) begin
          if (ph_cnt == GATE_LAST) begin
            gate   <= 1'b0;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end else begin
          if (ph_cnt == GAP_LAST) begin
            gate   <= 1'b1;
            ph_cnt <= '0;
            rng_q  <= range_in;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/frm_edge_counter.sv
module frm_edge_counter #(
  parameter int CNT_W = 24
) (
  input  logic             rec_clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             gate,
  output logic [CNT_W-1:0] cap_count,
  output logic             done_tog
);
  logic             gate_d;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d    <= 1'b0;
      cnt       <= '0;
      cap_count <= '0;
      done_tog  <= 1'b0;
    end else begin
      gate_d <= gate;
      if (!run) begin
        cnt <= '0;
      end else if (gate) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
      end else if (gate_d) begin
        cap_count <= cnt;
        done_tog  <= ~done_tog;
        cnt       <= '0;
      end
    end
  end
endmodule

// File: rtl/freq_ratio_meter.sv
module freq_ratio_meter
  import freq_ratio_meter_pkg::*;
#(
  parameter int GATE_TICKS = 10000,
  parameter int CNT_W      = 24
) (
  input  logic             sys_clk,
  input  logic             ref_clk,
  input  logic             rec_clk,
  input  logic             rst_n,
  input  logic             meas_en,
  input  logic             lock_ref_en,
  input  logic [1:0]       ref_range,
  output logic [CNT_W-1:0] ratio_count,
  output logic             ratio_valid,
  input  logic             ratio_ready
);
  logic             run_sys, run_ref, run_rec;
  logic             gate_ref, gate_rec;
  logic [CNT_W-1:0] cap_count;
  logic             done_tog, tog_s, tog_d;
  logic             res_arrive;

  assign run_sys = meas_en & ~lock_ref_en;

  frm_sync #(.WIDTH(1)) u_run_ref (.clk(ref_clk), .rst_n(rst_n), .d(run_sys), .q(run_ref));
  frm_sync #(.WIDTH(1)) u_run_rec (.clk(rec_clk), .rst_n(rst_n), .d(run_sys), .q(run_rec));

  frm_gate_gen #(.GATE_TICKS(GATE_TICKS)) u_gate (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .run     (run_ref),
    .range_in(range_t'(ref_range)),
    .gate    (gate_ref)
  );

  frm_sync #(.WIDTH(1)) u_gate_rec (.clk(rec_clk), .rst_n(rst_n), .d(gate_ref), .q(gate_rec));

  frm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .rec_clk  (rec_clk),
    .rst_n    (rst_n),
    .run      (run_rec),
    .gate     (gate_rec),
    .cap_count(cap_count),
    .done_tog (done_tog)
  );

  frm_sync #(.WIDTH(1)) u_tog_sys (.clk(sys_clk), .rst_n(rst_n), .d(done_tog), .q(tog_s));

  assign res_arrive = tog_s ^ tog_d;

  // cap_count is held for a whole window after the toggle, so it is stable here
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_d       <= 1'b0;
      ratio_valid <= 1'b0;
      ratio_count <= '0;
    end else begin
      tog_d <= tog_s;
      if (!run_sys) begin
        ratio_valid <= 1'b0;
      end else if (res_arrive) begin
        ratio_count <= cap_count;
        ratio_valid <= 1'b1;
      end else if (ratio_ready) begin
        ratio_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/frm_checker.sv
module frm_checker #(
  parameter int CNT_W = 24
) (
  input logic             sys_clk,
  input logic             rst_n,
  input logic             meas_en,
  input logic             lock_ref_en,
  input logic             ratio_valid,
  input logic             ratio_ready,
  input logic [CNT_W-1:0] ratio_count,
  input logic             res_arrive
);
  p_abort_clears_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !meas_en |=> !ratio_valid);

  p_lock_blocks_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    lock_ref_en |=> !ratio_valid);

  p_hold_valid_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (ratio_valid && !ratio_ready && meas_en && !lock_ref_en) |=> ratio_valid);

  p_hold_data_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (ratio_valid && !ratio_ready && !res_arrive) |=> $stable(ratio_count));

  p_accept_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (ratio_valid && ratio_ready && !res_arrive) |=> !ratio_valid);

  p_new_result_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (res_arrive && meas_en && !lock_ref_en) |=> ratio_valid);
endmodule

bind freq_ratio_meter frm_checker #(.CNT_W(CNT_W)) u_chk (
  .sys_clk    (sys_clk),
  .rst_n      (rst_n),
  .meas_en    (meas_en),
  .lock_ref_en(lock_ref_en),
  .ratio_valid(ratio_valid),
  .ratio_ready(ratio_ready),
  .ratio_count(ratio_count),
  .res_arrive (res_arrive)
);

// File: tb/tb_freq_ratio_meter.sv
`timescale 1ns/1ps
module tb_freq_ratio_meter;
  localparam int GATE  = 16;
  localparam int CNT_W = 24;
  localparam real TREF = 40.0;

  logic sys_clk = 0, ref_clk = 0, rec_clk = 0, rst_n = 0;
  logic meas_en = 0, lock_ref_en = 0, ratio_ready = 0;
  logic [1:0] ref_range = 0;
  logic [CNT_W-1:0] ratio_count;
  logic ratio_valid;
  realtime rec_half = 4.0;

  int n_tests = 0, n_fail = 0;
  real exp_q[$];
  bit  done = 0;

  freq_ratio_meter #(.GATE_TICKS(GATE), .CNT_W(CNT_W)) dut (
    .sys_clk(sys_clk), .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n),
    .meas_en(meas_en), .lock_ref_en(lock_ref_en), .ref_range(ref_range),
    .ratio_count(ratio_count), .ratio_valid(ratio_valid), .ratio_ready(ratio_ready));

  always #10 sys_clk = ~sys_clk;
  always #(TREF/2.0) ref_clk = ~ref_clk;
  always #(rec_half) rec_clk = ~rec_clk;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  // Monitor: samples mid-cycle, pops on every handshake
  always begin
    @(negedge sys_clk); #5;
    if (ratio_valid && ratio_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R4", "unexpected result", real'(ratio_count), -1.0);
      end else begin
        real e;
        e = exp_q.pop_front();
        check((real'(ratio_count) - e <= 1.0) && (e - real'(ratio_count) <= 1.0),
              "R2", "ratio count", real'(ratio_count), e);
      end
    end
  end

  task automatic wait_valid(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge sys_clk);
      if (ratio_valid) return;
    end
  endtask

  task automatic accept();
    @(negedge sys_clk); ratio_ready = 1;
    @(negedge sys_clk); ratio_ready = 0;
  endtask

  // Driver: configure, push expectation, take one fresh result
  task automatic measure(input logic [1:0] rng, input realtime half, input string req);
    real e;
    @(negedge sys_clk); meas_en = 0;
    repeat (8) @(negedge sys_clk);
    ref_range = rng; rec_half = half;
    repeat (4) @(negedge sys_clk);
    meas_en = 1;
    e = real'(GATE) * real'(1 << rng) * TREF / (2.0 * half);
    exp_q.push_back(e);
    wait_valid(2000);
    check(ratio_valid, req, "result arrives", real'(ratio_valid), 1.0);
    accept();
    @(negedge sys_clk);
    check(exp_q.size() == 0, req, "scoreboard drained", real'(exp_q.size()), 0.0);
  endtask

  initial begin
    repeat (200000) @(posedge sys_clk);
    if (!done) begin
      check(0, "WD", "watchdog", 0.0, 1.0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge sys_clk);
    rst_n = 1;
    @(negedge sys_clk);
    check(!ratio_valid, "R8", "valid after reset", real'(ratio_valid), 0.0);
    check(ratio_count == 0, "R8", "count after reset", real'(ratio_count), 0.0);

    measure(2'd0, 4.0, "R1");   // /1 -> 80
    measure(2'd1, 4.0, "R1");   // /2 -> 160
    measure(2'd2, 5.0, "R1");   // /4 -> 256
    measure(2'd3, 4.0, "R1");   // /8 -> 640
    measure(2'd0, 3.0, "R2");   // non-integer 106.67
    measure(2'd0, 20.0, "R3");  // ratio 1 -> GATE

    // R4: back-pressure, valid holds, newest result kept
    exp_q.push_back(80.0);
    @(negedge sys_clk); meas_en = 0;
    repeat (8) @(negedge sys_clk);
    ref_range = 2'd0; rec_half = 4.0;
    @(negedge sys_clk); meas_en = 1;
    wait_valid(2000);
    repeat (150) @(negedge sys_clk);
    check(ratio_valid, "R4", "valid held under back-pressure", real'(ratio_valid), 1.0);
    accept();
    // R5: valid drops after the handshake
    #5;
    check(!ratio_valid, "R5", "valid after accept", real'(ratio_valid), 0.0);

    // R6: abort clears valid and blocks results
    wait_valid(2000);
    @(negedge sys_clk); meas_en = 0;
    @(negedge sys_clk); #5;
    check(!ratio_valid, "R6", "valid after disable", real'(ratio_valid), 0.0);
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge sys_clk);
        if (ratio_valid) seen = 1;
      end
      check(!seen, "R6", "no result while disabled", real'(seen), 0.0);
    end

    // R7: both modes set, nothing measured
    @(negedge sys_clk); lock_ref_en = 1; meas_en = 1;
    begin
      bit seen = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge sys_clk);
        if (ratio_valid) seen = 1;
      end
      check(!seen, "R7", "no result with lock mode", real'(seen), 0.0);
    end
    lock_ref_en = 0;
    measure(2'd1, 5.0, "R7");   // recovers once lock mode is cleared -> 128

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule